// File: doc/BRIEF.md
# Timer with selectable trigger output

This block is an up-counting timer that lives on a simple 32-bit word-addressed register bus. A prescaler divides the input clock. Each prescaler tick advances a counter, and the counter wraps to zero once it reaches the reload value. On every wrap, and on every software update request, the block raises an update event. That event copies the buffered prescaler value and the buffered reload value into the working copies that the counter uses.

A single trigger output paces downstream logic, such as a converter start input or the clock enable of a second timer. A 3-bit source field in the second control register selects what drives it. There are eight choices:
- the software update request;
- the counter-enable level;
- the update event;
- a compare-match pulse on the first compare value;
- one of four level outputs, each high while the counter is below its compare value.

Run control is a two-state machine. ST_HALT moves to ST_COUNT when the enable bit is set, and ST_COUNT returns to ST_HALT when the enable bit is cleared. Counting happens only in ST_COUNT. A software update acts in either state.

Top module: `tmr_trigger_timer`

## Requirements
- R1: After reset, every readable register reads zero, the trigger output is low and the run state is ST_HALT.
- R2: Registers sit at byte offsets 0x00 (control 1: bit 0 enable, bit 7 reload buffering), 0x04 (control 2: bits 6:4 trigger source), 0x14 (event: bit 0 software update), 0x28 (prescaler, 16 bits), 0x2C (reload), and 0x34/0x38/0x3C/0x40 (compare 1 to 4). Bits beyond the counter width read zero, so writing all ones to the reload register reads back 0x0000FFFF at the default width. The event register always reads zero.
- R3: While running, update events occur every (reload+1)×(prescaler+1) clocks. While halted, the counter holds its value.
- R4: Writing 1 to event bit 0 clears the counter and prescaler, loads both working copies and raises an update event in the next cycle. The request is not stored.
- R5: With control 1 bit 7 set, a new reload value takes effect only after the next update event. With that bit clear, it takes effect at once.
- R6: The prescaler value is always buffered and takes effect only after the next update event.
- R7: Source code 1: the trigger output follows the run state, which follows the enable bit one cycle later.
- R8: Source code 2: the trigger output is a one-cycle pulse per update event.
- R9: Source code 3: the trigger output is a one-cycle pulse in the first cycle that a counting step brings the counter to compare value 1. There is no pulse if that value exceeds the reload value.
- R10: Source codes 4 to 7: the trigger output is high while the counter is below compare value 1 to 4 respectively.
- R11: Source code 0: the trigger output is a one-cycle pulse after each software update request and is otherwise low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Bus access strobe |
| cpu_wr | input | 1 | Write when high, read when low |
| cpu_addr | input | ADDR_W (8) | Byte address of a 32-bit register |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, combinational, zero when not selected |
| trig_out | output | 1 | Selected trigger output |

## Verification
A bus write takes effect on the clock edge that captures it. Read data is combinational, so the bench samples it within the same access.

Update, software-update and compare pulses appear in the cycle after the edge that causes them. The counter-enable source follows a control write one edge later than the write.

The bench samples the trigger output only on falling edges. It measures pulse spacing in clock counts between rising edges, and it always waits for two or three rises after any reconfiguration before comparing a gap. Level sources are checked by counting high samples over a window of exactly ten periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BUS_W = 32;
    localparam int N_CMP = 4;  // fixed by the 3-bit source encoding

    localparam logic [7:0] OFS_CTRL_A   = 8'h00;
    localparam logic [7:0] OFS_CTRL_B   = 8'h04;
    localparam logic [7:0] OFS_EVENT    = 8'h14;
    localparam logic [7:0] OFS_DIVIDER  = 8'h28;
    localparam logic [7:0] OFS_RELOAD   = 8'h2C;
    localparam logic [7:0] OFS_CMP_BASE = 8'h34;

    localparam int BIT_RUN     = 0;
    localparam int BIT_BUF     = 7;
    localparam int SEL_LO      = 4;
    localparam int SEL_HI      = 6;
    localparam int BIT_SW_UPD  = 0;

    typedef enum logic [0:0] {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_st_e;

    typedef enum logic [2:0] {
        TM_SWUPD  = 3'd0,
        TM_ENABLE = 3'd1,
        TM_UPDATE = 3'd2,
        TM_CMP    = 3'd3,
        TM_LVL1   = 3'd4,
        TM_LVL2   = 3'd5,
        TM_LVL3   = 3'd6,
        TM_LVL4   = 3'd7
    } trig_mode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_sel,
    input  logic                          cpu_wr,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [BUS_W-1:0]              cpu_wdata,
    output logic [BUS_W-1:0]              cpu_rdata,
    output logic                          run_en,
    output logic                          buf_en,
    output trig_mode_e                    trig_mode,
    output logic [PSC_W-1:0]              div_pre,
    output logic [CNT_W-1:0]              reload_pre,
    output logic [N_CMP-1:0][CNT_W-1:0]   cmp_val,
    output logic                          ug_req
);
    localparam logic [ADDR_W-1:0] A_CTRL_A = ADDR_W'(OFS_CTRL_A);
    localparam logic [ADDR_W-1:0] A_CTRL_B = ADDR_W'(OFS_CTRL_B);
    localparam logic [ADDR_W-1:0] A_EVENT  = ADDR_W'(OFS_EVENT);
    localparam logic [ADDR_W-1:0] A_DIV    = ADDR_W'(OFS_DIVIDER);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);

    logic wr_hit;
    logic [BUS_W-1:0] rd_mux;
    logic unused_wdata;

    assign wr_hit       = cpu_sel && cpu_wr;
    assign ug_req       = wr_hit && (cpu_addr == A_EVENT) && cpu_wdata[BIT_SW_UPD];
    assign unused_wdata = ^cpu_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en     <= 1'b0;
            buf_en     <= 1'b0;
            trig_mode  <= TM_SWUPD;
            div_pre    <= '0;
            reload_pre <= '0;
        end else if (wr_hit) begin
            if (cpu_addr == A_CTRL_A) begin
                run_en <= cpu_wdata[BIT_RUN];
                buf_en <= cpu_wdata[BIT_BUF];
            end
            if (cpu_addr == A_CTRL_B) begin
                trig_mode <= trig_mode_e'(cpu_wdata[SEL_HI:SEL_LO]);
            end
            if (cpu_addr == A_DIV) begin
                div_pre <= cpu_wdata[PSC_W-1:0];
            end
            if (cpu_addr == A_RELOAD) begin
                reload_pre <= cpu_wdata[CNT_W-1:0];
            end
        end
    end

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(OFS_CMP_BASE + 8'(4 * i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_val[i] <= '0;
            end else if (wr_hit && (cpu_addr == A_CMP)) begin
                cmp_val[i] <= cpu_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (cpu_addr == A_CTRL_A) begin
            rd_mux[BIT_RUN] = run_en;
            rd_mux[BIT_BUF] = buf_en;
        end
        if (cpu_addr == A_CTRL_B) begin
            rd_mux[SEL_HI:SEL_LO] = trig_mode;
        end
        if (cpu_addr == A_DIV) begin
            rd_mux = BUS_W'(div_pre);
        end
        if (cpu_addr == A_RELOAD) begin
            rd_mux = BUS_W'(reload_pre);
        end
        for (int i = 0; i < N_CMP; i++) begin
            if (cpu_addr == ADDR_W'(OFS_CMP_BASE + 8'(4 * i))) begin
                rd_mux = BUS_W'(cmp_val[i]);
            end
        end
    end

    assign cpu_rdata = (cpu_sel && !cpu_wr) ? rd_mux : '0;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             buf_en,
    input  logic             ug_req,
    input  logic [PSC_W-1:0] div_pre,
    input  logic [CNT_W-1:0] reload_pre,
    output logic             counting,
    output logic [CNT_W-1:0] cnt,
    output logic [PSC_W-1:0] pcnt,
    output logic [PSC_W-1:0] div_act,
    output logic             upd_evt,
    output logic             step
);
    run_st_e st_q, st_d;
    logic [CNT_W-1:0] reload_sh;
    logic [CNT_W-1:0] reload_eff;
    logic             tick;
    logic             wrap;
    logic             load_sh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT:  if (run_en)  st_d = ST_COUNT;
            ST_COUNT: if (!run_en) st_d = ST_HALT;
        endcase
    end

    // outputs of the run state
    always_comb begin
        counting   = (st_q == ST_COUNT);
        reload_eff = buf_en ? reload_sh : reload_pre;
        tick       = counting && (pcnt == div_act);
        wrap       = tick && (cnt == reload_eff);
        load_sh    = ug_req || wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
            cnt  <= '0;
        end else if (ug_req) begin
            pcnt <= '0;
            cnt  <= '0;
        end else if (counting) begin
            if (tick) begin
                pcnt <= '0;
                cnt  <= wrap ? '0 : cnt + CNT_W'(1);
            end else begin
                pcnt <= pcnt + PSC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_act   <= '0;
            reload_sh <= '0;
        end else if (load_sh) begin
            div_act   <= div_pre;
            reload_sh <= reload_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_evt <= 1'b0;
            step    <= 1'b0;
        end else begin
            upd_evt <= load_sh;
            step    <= tick && !ug_req;
        end
    end
endmodule

// File: rtl/tmr_trig.sv
module tmr_trig
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  trig_mode_e                  trig_mode,
    input  logic                        counting,
    input  logic                        ug_req,
    input  logic                        upd_evt,
    input  logic                        step,
    input  logic [CNT_W-1:0]            cnt,
    input  logic [N_CMP-1:0][CNT_W-1:0] cmp_val,
    output logic                        trig_out
);
    logic             ug_q;
    logic [N_CMP-1:0] lvl;
    logic             cmp_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ug_q <= 1'b0;
        else        ug_q <= ug_req;
    end

    for (genvar i = 0; i < N_CMP; i++) begin : g_lvl
        assign lvl[i] = (cnt < cmp_val[i]);
    end

    assign cmp_pulse = step && (cnt == cmp_val[0]);

    always_comb begin
        trig_out = 1'b0;
        unique case (trig_mode)
            TM_SWUPD:  trig_out = ug_q;
            TM_ENABLE: trig_out = counting;
            TM_UPDATE: trig_out = upd_evt;
            TM_CMP:    trig_out = cmp_pulse;
            TM_LVL1:   trig_out = lvl[0];
            TM_LVL2:   trig_out = lvl[1];
            TM_LVL3:   trig_out = lvl[2];
            TM_LVL4:   trig_out = lvl[3];
        endcase
    end
endmodule

// File: rtl/tmr_trigger_timer.sv
module tmr_trigger_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              trig_out
);
    logic                        run_en;
    logic                        buf_en;
    trig_mode_e                  trig_mode;
    logic [PSC_W-1:0]            div_pre;
    logic [CNT_W-1:0]            reload_pre;
    logic [N_CMP-1:0][CNT_W-1:0] cmp_val;
    logic                        ug_req;
    logic                        counting;
    logic [CNT_W-1:0]            cnt;
    logic [PSC_W-1:0]            pcnt;
    logic [PSC_W-1:0]            div_act;
    logic                        upd_evt;
    logic                        step;

    tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .run_en(run_en), .buf_en(buf_en), .trig_mode(trig_mode),
        .div_pre(div_pre), .reload_pre(reload_pre), .cmp_val(cmp_val),
        .ug_req(ug_req)
    );

    tmr_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run_en(run_en), .buf_en(buf_en), .ug_req(ug_req),
        .div_pre(div_pre), .reload_pre(reload_pre),
        .counting(counting), .cnt(cnt), .pcnt(pcnt), .div_act(div_act),
        .upd_evt(upd_evt), .step(step)
    );

    tmr_trig #(.CNT_W(CNT_W)) u_trig (
        .clk(clk), .rst_n(rst_n),
        .trig_mode(trig_mode), .counting(counting), .ug_req(ug_req),
        .upd_evt(upd_evt), .step(step), .cnt(cnt), .cmp_val(cmp_val),
        .trig_out(trig_out)
    );
endmodule

// File: rtl/tmr_trigger_timer_chk.sv
module tmr_trigger_timer_chk #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_out,
    input logic [2:0]       trig_mode,
    input logic             run_en,
    input logic             counting,
    input logic             ug_req,
    input logic [CNT_W-1:0] cnt,
    input logic [PSC_W-1:0] pcnt,
    input logic [PSC_W-1:0] div_act,
    input logic [PSC_W-1:0] div_pre
);
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !ug_req) |=> $stable(cnt));  // R3

    AST_SWUPD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ug_req |=> (cnt == '0 && pcnt == '0));  // R4

    AST_SWUPD_LOADS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        ug_req |=> (div_act == $past(div_pre)));  // R6

    AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == 3'd1) |-> (trig_out == $past(run_en)));  // R7

    AST_UPDATE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == 3'd2 && trig_out) |-> (cnt == '0 && pcnt == '0));  // R8

    AST_SWUPD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == 3'd0 && !$past(ug_req)) |-> !trig_out);  // R11
endmodule

bind tmr_trigger_timer tmr_trigger_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_out(trig_out), .trig_mode(trig_mode),
    .run_en(run_en), .counting(counting), .ug_req(ug_req), .cnt(cnt),
    .pcnt(pcnt), .div_act(div_act), .div_pre(div_pre)
);

// File: tb/tmr_trigger_timer_bench.sv
module tmr_trigger_timer_bench;
    localparam logic [7:0] A_CA  = 8'h00;
    localparam logic [7:0] A_CB  = 8'h04;
    localparam logic [7:0] A_EV  = 8'h14;
    localparam logic [7:0] A_DV  = 8'h28;
    localparam logic [7:0] A_RL  = 8'h2C;
    localparam logic [7:0] A_C0  = 8'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        trig_out;

    always #5 clk = ~clk;

    tmr_trigger_timer u_tmr_trigger_timer (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .trig_out(trig_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // falling-edge monitor of the trigger output
    int rises = 0, last_rise = 0, last_gap = 0, high_cnt = 0, run_len = 0, last_width = 0;
    logic prev_t = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (trig_out) begin
                high_cnt++;
                if (!prev_t) begin
                    rises++;
                    last_gap  = cyc - last_rise;
                    last_rise = cyc;
                    run_len   = 0;
                end
                run_len++;
            end else if (prev_t) begin
                last_width = run_len;
            end
            prev_t = trig_out;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        cpu_sel = 1'b0;
    endtask

    task automatic nedges(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_rise(input string tag);
        int r0 = rises;
        int n = 0;
        while (rises == r0 && n < 2000) begin
            @(negedge clk); #1; n++;
        end
        if (rises == r0) chk({tag, " trigger pulse timeout"}, 0, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(A_CA, d); chk("R1 ctrl_a after reset", d, 0);
        bus_rd(A_CB, d); chk("R1 ctrl_b after reset", d, 0);
        bus_rd(A_DV, d); chk("R1 divider after reset", d, 0);
        bus_rd(A_RL, d); chk("R1 reload after reset", d, 0);
        for (int i = 0; i < 4; i++) begin
            bus_rd(A_C0 + 8'(4 * i), d); chk("R1 compare after reset", d, 0);
        end
        chk("R1 trigger low after reset", int'(trig_out), 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bus_wr(A_RL, 32'hFFFF_FFFF); bus_rd(A_RL, d); chk("R2 reload width", d, 32'h0000_FFFF);
        bus_wr(A_DV, 32'hFFFF_FFFF); bus_rd(A_DV, d); chk("R2 divider width", d, 32'h0000_FFFF);
        bus_wr(A_CB, 32'hFFFF_FFFF); bus_rd(A_CB, d); chk("R2 ctrl_b field", d, 32'h70);
        for (int i = 0; i < 4; i++) begin
            bus_wr(A_C0 + 8'(4 * i), 32'hABCD_0000 | (32'h1000 + 32'(i * 'h111)));
        end
        for (int i = 0; i < 4; i++) begin
            bus_rd(A_C0 + 8'(4 * i), d); chk("R2 compare readback", d, 32'h1000 + i * 'h111);
        end
        bus_wr(A_CA, 32'hFFFF_FFFF); bus_rd(A_CA, d); chk("R2 ctrl_a bits", d, 32'h81);
        bus_wr(A_CA, 32'h0);
        bus_wr(A_EV, 32'hFFFF_FFFE); bus_rd(A_EV, d); chk("R2 event reads zero", d, 0);
        bus_wr(A_CB, 32'h0);
        for (int i = 0; i < 4; i++) bus_wr(A_C0 + 8'(4 * i), 32'h0);
    endtask

    task automatic t_period();
        int r0;
        bus_wr(A_CB, 32'h20);
        bus_wr(A_DV, 2); bus_wr(A_RL, 4); bus_wr(A_CA, 32'h80);
        bus_wr(A_EV, 1);
        nedges(3); r0 = rises; nedges(60);
        chk("R3 halted gives no update", rises - r0, 0);
        bus_wr(A_CA, 32'h81);
        wait_rise("R3"); wait_rise("R3");
        chk("R3 period div2 reload4", last_gap, 15);
        nedges(3); chk("R8 update pulse width", last_width, 1);
        wait_rise("R3"); chk("R3 period repeat", last_gap, 15);
        bus_wr(A_DV, 0); bus_wr(A_RL, 6); bus_wr(A_EV, 1);
        wait_rise("R3"); wait_rise("R3"); wait_rise("R3");
        chk("R3 period div0 reload6", last_gap, 7);
        bus_wr(A_DV, 3); bus_wr(A_RL, 1); bus_wr(A_EV, 1);
        wait_rise("R3"); wait_rise("R3"); wait_rise("R3");
        chk("R3 period div3 reload1", last_gap, 8);
    endtask

    task automatic t_preload();
        bus_wr(A_DV, 2); bus_wr(A_RL, 4); bus_wr(A_EV, 1);
        wait_rise("R5"); wait_rise("R5"); wait_rise("R5");
        bus_wr(A_RL, 9);
        wait_rise("R5"); chk("R5 buffered reload waits", last_gap, 15);
        wait_rise("R5"); chk("R5 buffered reload applied", last_gap, 30);
        bus_wr(A_CA, 32'h01); bus_wr(A_RL, 4);
        wait_rise("R5"); chk("R5 unbuffered reload immediate", last_gap, 15);
        bus_wr(A_CA, 32'h81);
        wait_rise("R6"); wait_rise("R6");
        bus_wr(A_DV, 0);
        wait_rise("R6"); chk("R6 divider waits for update", last_gap, 15);
        wait_rise("R6"); chk("R6 divider applied", last_gap, 5);
    endtask

    task automatic t_swupd();
        logic [31:0] d;
        bus_wr(A_DV, 2); bus_wr(A_EV, 1);
        wait_rise("R4"); wait_rise("R4"); wait_rise("R4");
        chk("R4 period before request", last_gap, 15);
        nedges(5); bus_wr(A_EV, 1);
        wait_rise("R4"); chk("R4 request restarts period", last_gap, 6);
        wait_rise("R4"); chk("R4 full period after request", last_gap, 15);
        bus_rd(A_EV, d); chk("R4 request not stored", d, 0);
    endtask

    task automatic t_mode0();
        int r0;
        bus_wr(A_CB, 32'h00);
        nedges(2); r0 = rises; nedges(50);
        chk("R11 no pulse without request", rises - r0, 0);
        bus_wr(A_EV, 1);
        wait_rise("R11"); nedges(3);
        chk("R11 request pulse width", last_width, 1);
        chk("R11 single pulse per request", rises - r0, 1);
    endtask

    task automatic t_mode1();
        bus_wr(A_CB, 32'h10); nedges(2);
        chk("R7 high while running", int'(trig_out), 1);
        bus_wr(A_CA, 32'h80); nedges(2);
        chk("R7 low when halted", int'(trig_out), 0);
        bus_wr(A_CA, 32'h81); nedges(2);
        chk("R7 high after restart", int'(trig_out), 1);
    endtask

    task automatic t_cmp();
        int r0;
        bus_wr(A_CB, 32'h30); bus_wr(A_C0, 2);
        wait_rise("R9"); wait_rise("R9"); wait_rise("R9");
        chk("R9 compare pulse period", last_gap, 15);
        nedges(3); chk("R9 compare pulse width", last_width, 1);
        bus_wr(A_C0, 7); nedges(2); r0 = rises; nedges(60);
        chk("R9 no pulse past reload", rises - r0, 0);
    endtask

    task automatic t_levels();
        int h0;
        int exp_hi[4] = '{60, 150, 0, 120};
        bus_wr(A_C0, 2); bus_wr(A_C0 + 8'd4, 5); bus_wr(A_C0 + 8'd8, 0); bus_wr(A_C0 + 8'd12, 4);
        for (int m = 0; m < 4; m++) begin
            bus_wr(A_CB, 32'(m + 4) << 4);
            nedges(3); h0 = high_cnt; nedges(150);
            chk($sformatf("R10 level source %0d high count", m + 4), high_cnt - h0, exp_hi[m]);
        end
    endtask

    initial begin
        #1_000_000;
        chk("watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        t_reset();
        t_regs();
        t_period();
        t_preload();
        t_swupd();
        t_mode0();
        t_mode1();
        t_cmp();
        t_levels();
        finish_run();
    end
endmodule